// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block runs on the host side of a two-wire serial bus. After a host reset or a power-up it brings a memory slave that is stuck mid-transfer back into step with the host. The slave may be holding SDA low for an acknowledge or for a zero data bit. A one-cycle request starts a fixed pattern on the open-drain enables of SCL and SDA. The pattern is a start condition, then nine dummy clocks with SDA released, then a start condition with no clock pulse in between, then a stop condition. The bus then sits idle and a one-cycle done pulse is given.

All bus timing comes from one quarter period, counted in system clock cycles. The quarter period is taken from an input at the moment a request is accepted. A parameter sets a hold delay, which places every SDA change the block makes while SCL is low a safe distance after the falling edge of SCL. A normal bus master shares the pins. The sequencer pulls a line only while it is busy.

After the stop condition the block checks that SDA has really returned high. If SDA is still low, it raises an error flag that stays set until the next request. Running the sequence once after power-up initialization is the intended use.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset, and whenever the block is idle, both pull enables are 0 (lines released), busy is 0 and done is 0.
- R2: The first bus event of a sequence is a start: SDA falls while SCL is high. Before each start, SCL and SDA are both high for at least one quarter period Q, where Q is the quarter input and a value of 0 counts as 1.
- R3: Between the first and the second start there are exactly 10 SCL rising edges: 9 dummy clocks with SDA released by the sequencer, and 1 edge that sets up the second start.
- R4: Each dummy clock is high for 2·Q cycles and low for 2·Q cycles. The low time between the second start and the stop is also 2·Q.
- R5: After the second start there is exactly one more SCL rising edge, then a stop (SDA rises while SCL is high), and no further bus event.
- R6: Whenever the sequencer changes its SDA enable while SCL is pulled low, SCL has been low for at least HOLD_CYC cycles (default 15, which is 300 ns at 50 MHz).
- R7: done is high for exactly one cycle, 45·Q + HOLD_CYC clock edges after the edge that accepts the request.
- R8: A request that arrives while busy is high is ignored. The running sequence keeps its timing and gives a single done pulse.
- R9: err is valid from the done cycle on. It is 1 when SDA was low on the last cycle of the quarter that follows the stop edge, and 0 otherwise. An accepted request clears it.
- R10: The quarter input is captured when a request is accepted. Changing it during a sequence has no effect on that sequence's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Recovery request, one cycle |
| quarter_i | input | QTR_W | Quarter bus period in clock cycles (0 counts as 1) |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress (includes the done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | SDA still low after the stop |

## Verification
The bench sweeps the quarter period from 0 to 6 and rebuilds the bus waveform from the pins. It checks the event order: start, ten rises, start, one rise, stop. A design with an off-by-one in the clock counter would show nine or eleven rises. A design that slipped an extra pulse before the second start would break the tail of the pattern. Each high and low width is measured, and the SDA release after SCL falls is timed against the hold value, so a design that released SDA on the SCL edge fails that check. A slave model holds SDA low and releases it after a chosen number of SCL falls, or never, which exercises the error flag. One run raises a request and changes the quarter input mid-sequence, to catch a design that restarts or retimes itself.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,    // both lines high, start setup
    PH_SFALL,  // SDA low with SCL high: leading start
    PH_HOLD,   // SCL low, SDA still low, hold delay
    PH_REL,    // SCL low, SDA released
    PH_CKHI,   // dummy clock high
    PH_CKLO,   // dummy clock low
    PH_RHI,    // SCL high, SDA high: restart setup
    PH_RFALL,  // SDA low with SCL high: restart
    PH_RLO,    // SCL low, SDA low
    PH_PHI,    // SCL high, SDA low: stop setup
    PH_PREL,   // SDA released with SCL high: stop
    PH_DONE
  } phase_t;

  // Cycles spent in a phase for quarter q and hold delay h.
  function automatic int unsigned phase_len(phase_t ph, int unsigned q, int unsigned h);
    case (ph)
      PH_HOLD:                    return h;
      PH_CKHI, PH_CKLO, PH_RLO:   return 2 * q;
      PH_IDLE, PH_DONE:           return 1;
      default:                    return q;
    endcase
  endfunction

  function automatic phase_t next_phase(phase_t ph, logic last_clk);
    case (ph)
      PH_PRE:   return PH_SFALL;
      PH_SFALL: return PH_HOLD;
      PH_HOLD:  return PH_REL;
      PH_REL:   return PH_CKHI;
      PH_CKHI:  return PH_CKLO;
      PH_CKLO:  return last_clk ? PH_RHI : PH_CKHI;
      PH_RHI:   return PH_RFALL;
      PH_RFALL: return PH_RLO;
      PH_RLO:   return PH_PHI;
      PH_PHI:   return PH_PREL;
      PH_PREL:  return PH_DONE;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic logic scl_pull(phase_t ph);
    return (ph == PH_HOLD) || (ph == PH_REL) || (ph == PH_CKLO) || (ph == PH_RLO);
  endfunction

  function automatic logic sda_pull(phase_t ph);
    return (ph == PH_SFALL) || (ph == PH_HOLD) || (ph == PH_RFALL) ||
           (ph == PH_RLO) || (ph == PH_PHI);
  endfunction

  function automatic logic timed_phase(phase_t ph);
    return (ph != PH_IDLE) && (ph != PH_DONE);
  endfunction

endpackage

// File: rtl/brs_timer.sv
module brs_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
  import brs_pkg::*;
#(
  parameter int NUM_CLOCKS = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   expire,
  output phase_t phase,
  output phase_t nxt,
  output logic   step,
  output logic   load
);
  localparam int PC_W = $clog2(NUM_CLOCKS + 1);

  logic [PC_W-1:0] ck_cnt_q;
  logic            last_clk;

  assign last_clk = (ck_cnt_q == PC_W'(NUM_CLOCKS - 1));

  always_comb begin
    if (phase == PH_IDLE)      step = accept;
    else if (phase == PH_DONE) step = 1'b1;
    else                       step = expire;
    nxt  = (phase == PH_IDLE) ? PH_PRE : next_phase(phase, last_clk);
    load = step && timed_phase(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ck_cnt_q <= '0;
    end else begin
      if (step) phase <= nxt;
      if (accept)                            ck_cnt_q <= '0;
      else if (phase == PH_CKLO && expire)   ck_cnt_q <= ck_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/brs_sense.sv
module brs_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic final_en,
  input  logic sda_i,
  output logic err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_o <= 1'b0;
    else if (accept)   err_o <= 1'b0;
    else if (final_en) err_o <= !sda_i;
  end
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import brs_pkg::*;
#(
  parameter int QTR_W      = 8,
  parameter int HOLD_CYC   = 15,
  parameter int NUM_CLOCKS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [QTR_W-1:0] quarter_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int CNT_W  = (QTR_W + 2 > HOLD_W) ? QTR_W + 2 : HOLD_W;

  phase_t           phase, nxt;
  logic             step, load, expire, accept, final_en;
  logic [QTR_W-1:0] q_lat, q_norm;
  int unsigned      eff_q;
  logic [CNT_W-1:0] load_val;

  assign accept   = req_i && (phase == PH_IDLE);
  assign q_norm   = (quarter_i == '0) ? QTR_W'(1) : quarter_i;
  assign eff_q    = (phase == PH_IDLE) ? int'(q_norm) : int'(q_lat);
  assign load_val = CNT_W'(phase_len(nxt, eff_q, HOLD_CYC) - 1);
  assign final_en = expire && (phase == PH_PREL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_lat <= QTR_W'(1);
    else if (accept) q_lat <= q_norm;
  end

  brs_fsm #(.NUM_CLOCKS(NUM_CLOCKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .expire(expire),
    .phase(phase), .nxt(nxt), .step(step), .load(load)
  );

  brs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expire(expire)
  );

  brs_sense u_sense (
    .clk(clk), .rst_n(rst_n), .accept(accept), .final_en(final_en),
    .sda_i(sda_i), .err_o(err_o)
  );

  assign scl_oe_o = scl_pull(phase);
  assign sda_oe_o = sda_pull(phase);
  assign busy_o   = (phase != PH_IDLE);
  assign done_o   = (phase == PH_DONE);
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int HOLD_CYC   = 15,
  parameter int NUM_CLOCKS = 9
) (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic sda_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  logic [15:0] low_age;
  logic [7:0]  rel_cnt;
  logic        scl_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_age  <= '0;
      rel_cnt  <= '0;
      scl_oe_q <= 1'b0;
    end else begin
      scl_oe_q <= scl_oe_o;
      if (!scl_oe_o)             low_age <= '0;
      else if (low_age != '1)    low_age <= low_age + 1'b1;
      if (req_i && !busy_o)      rel_cnt <= '0;
      else if (scl_oe_q && !scl_oe_o) rel_cnt <= rel_cnt + 1'b1;
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  assert_clock_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rel_cnt == 8'(NUM_CLOCKS + 2)));

  assert_sda_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe_o && $past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o))) |-> (low_age >= 16'(HOLD_CYC)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == !$past(sda_i)));
endmodule

bind bus_recover_seq brs_checker #(.HOLD_CYC(HOLD_CYC), .NUM_CLOCKS(NUM_CLOCKS)) u_brs_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .sda_i(sda_i), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/test_bus_recover_seq.sv
module test_bus_recover_seq;
  localparam int HOLD = 15;
  localparam int EV_RISE = 1, EV_START = 2, EV_STOP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, req;
  logic [7:0] qtr;
  logic       scl_oe, sda_oe, busy, done, err;
  logic       slave_low;
  wire        sda_i = !(sda_oe || slave_low);

  bus_recover_seq #(.QTR_W(8), .HOLD_CYC(HOLD), .NUM_CLOCKS(9)) i_bus_recover_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .quarter_i(qtr), .sda_i(sda_i),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, fails = 0;
  int ev[0:31];   int n_ev;
  int hi_w[0:31]; int n_hi;
  int lo_w[0:31]; int n_lo;
  int st_pre[0:7]; int n_st;
  int hi_run, lo_run, pre_run, hold_bad, slave_left;
  logic scl_p = 1'b1, sda_p = 1'b1, sdaoe_p = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic scl_b, sda_b;
    scl_b = !scl_oe;
    sda_b = sda_i;
    if (scl_b && scl_p && sda_p && !sda_b && n_ev < 32) begin
      ev[n_ev] = EV_START; n_ev++;
      if (n_st < 8) begin st_pre[n_st] = pre_run; n_st++; end
    end
    if (scl_b && scl_p && !sda_p && sda_b && n_ev < 32) begin ev[n_ev] = EV_STOP; n_ev++; end
    if (scl_b && !scl_p && n_ev < 32) begin ev[n_ev] = EV_RISE; n_ev++; end
    if (!scl_b && scl_p && n_hi < 32) begin hi_w[n_hi] = hi_run; n_hi++; end
    if (scl_b && !scl_p && n_lo < 32) begin lo_w[n_lo] = lo_run; n_lo++; end
    if (!scl_b && (sda_oe != sdaoe_p) && lo_run < HOLD) hold_bad++;
    hi_run  = scl_b ? hi_run + 1 : 0;
    lo_run  = scl_b ? 0 : lo_run + 1;
    pre_run = (scl_b && sda_b) ? pre_run + 1 : 0;
    if (!scl_b && scl_p && slave_left > 0) begin
      slave_left--;
      if (slave_left == 0) slave_low = 1'b0;
    end
    scl_p = scl_b; sda_p = sda_b; sdaoe_p = sda_oe;
  end

  // stuck: -2 free slave, -1 never releases, k>0 releases after k SCL falls
  task automatic run(input int q, input int stuck, input bit disturb);
    int qq, n, exp_n, rises, bad, ndone;
    qq = (q == 0) ? 1 : q;
    @(negedge clk);
    n_ev = 0; n_hi = 0; n_lo = 0; n_st = 0; hold_bad = 0;
    slave_low  = (stuck != -2);
    slave_left = (stuck > 0) ? stuck : -1;
    qtr = 8'(q); req = 1'b1; n = 0;
    while (n < 5000) begin
      @(negedge clk); n++;
      if (n == 1) req = 1'b0;
      if (disturb && n == 20) begin req = 1'b1; qtr = 8'(q + 3); end
      if (disturb && n == 21) req = 1'b0;
      if (done) break;
    end
    exp_n = 45 * qq + HOLD + 1;
    chk(n == exp_n, "R7 done timing", n, exp_n);
    chk(err == (stuck == -1), "R9 err flag", err, stuck == -1);
    ndone = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) ndone++;
      if (i == 0) chk(!busy && !scl_oe && !sda_oe, "R1 idle after done", busy, 0);
    end
    chk(ndone == 0, disturb ? "R8 single done" : "R7 single done", ndone, 0);
    if (stuck == -2) begin
      chk(n_ev == 14, "R5 event count", n_ev, 14);
      chk(ev[0] == EV_START, "R2 leading start", ev[0], EV_START);
      rises = 0;
      for (int i = 1; i < 11; i++) if (ev[i] == EV_RISE) rises++;
      chk(rises == 10 && ev[11] == EV_START, "R3 rises before restart", rises, 10);
      chk(ev[12] == EV_RISE && ev[13] == EV_STOP, "R5 rise then stop", ev[13], EV_STOP);
      chk(n_st == 2 && st_pre[1] >= qq, "R2 restart setup", st_pre[1], qq);
      bad = 0;
      for (int i = 1; i < 10; i++) if (hi_w[i] != 2 * qq) bad++;
      for (int i = 1; i < 11; i++) if (lo_w[i] != 2 * qq) bad++;
      chk(bad == 0 && lo_w[0] == HOLD + qq, "R4 clock widths", bad, 0);
      chk(hold_bad == 0, "R6 sda hold", hold_bad, 0);
    end
    slave_low = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; qtr = 8'd1; slave_low = 1'b0; slave_left = -1;
    n_ev = 0; n_hi = 0; n_lo = 0; n_st = 0; hi_run = 0; lo_run = 0; pre_run = 0; hold_bad = 0;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state", {scl_oe, sda_oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !err, "R1 idle after reset", busy, 0);
    for (int q = 0; q <= 6; q++) run(q, -2, 1'b0);
    run(2, -1, 1'b0);
    run(2, 1, 1'b0);
    run(2, 5, 1'b0);
    run(3, 10, 1'b0);
    run(2, -1, 1'b0);
    run(2, -2, 1'b0);   // err cleared by new request (R9)
    run(3, -2, 1'b1);   // R8 and R10: request and quarter change mid-run
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule